// File: doc/BRIEF.md
# Decoupled-Branch Instruction Fetch Unit

This block owns the program counter of a small 16-bit pipelined core. It reads one instruction word at a time from a memory port that it shares with a data-side unit. Every control-flow decision is settled here, so the decode stage never sees a branch or a jump. The execute stage decides conditions and computes jump targets ahead of time and pushes them into two small queues inside this unit. A conditional branch consumes one condition bit and a register jump consumes one target address. When the queue that an instruction needs is empty, fetch simply waits. No delay slots or filler instructions are ever needed.

All other instructions go to decode over a valid/ready stream. The PC-capture instruction also sends a second beat: its own address plus a signed 8-bit displacement. Later stages use that value as a return address. Access to memory alternates with the data side. After each instruction read, the data side gets the next turn. If it is not asking, the turn comes straight back.

Top module: `ifu_top`

## Requirements
- R1: While reset is held, `dec_valid` and `mem_rd` are low and `mem_addr` is 0x0000; the first read after reset is at address 0x0000.
- R2: An instruction whose opcode (bits 15:12) is not 0x0, 0x1 or 0x7 is sent to decode unchanged, and the next read is at its address plus one.
- R3: Opcode 0x0 (register jump) removes one entry from the jump queue, the next read is at that entry's address, and no decode beat is produced.
- R4: Opcode 0x1 (conditional branch) removes one bit from the condition queue; a 1 makes the next read address equal the branch's own address plus bits 11:0 sign-extended, a 0 makes it the address plus one; no decode beat is produced.
- R5: A jump with an empty jump queue, or a branch with an empty condition queue, holds the unit with no memory read and no decode beat until an entry arrives.
- R6: Opcode 0x7 (PC capture) is sent to decode, the very next decode beat is its own address plus bits 7:0 sign-extended (modulo 2^16), and the next read is at its address plus one.
- R7: In the cycle after every read, `dside_gnt` equals `dside_req`; `dside_gnt` is never high while `dside_req` is low, and a read never coincides with `dside_gnt`.
- R8: `mem_rd` is a one-cycle pulse; the instruction is taken from `mem_rdata` in the cycle after the pulse, and no new read is issued before that instruction has been handled.
- R9: While `dec_valid` is high and `dec_ready` is low, `dec_valid` stays high and `dec_data` does not change.
- R10: Each queue returns entries in arrival order, holds up to its depth (default 4), and drives its ready output low while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Instruction read strobe |
| mem_addr | output | 16 | Instruction read address (current PC) |
| mem_rdata | input | 16 | Instruction word, valid the cycle after `mem_rd` |
| dside_req | input | 1 | Data-side unit wants the memory port |
| dside_gnt | output | 1 | Data-side unit owns the memory port this cycle |
| cc_valid | input | 1 | Condition bit offered by execute |
| cc_ready | output | 1 | Condition queue has room |
| cc_bit | input | 1 | Condition value (1 = take branch) |
| jt_valid | input | 1 | Jump target offered by execute |
| jt_ready | output | 1 | Jump queue has room |
| jt_addr | input | 16 | Jump target address |
| dec_valid | output | 1 | Beat for decode is present |
| dec_ready | input | 1 | Decode accepts the beat |
| dec_data | output | 16 | Forwarded instruction or captured PC value |

## Verification
A mixed program runs taken and untaken branches with forward and backward displacements, jumps to high and low addresses, and PC captures with both displacement signs. The run is repeated with decode always ready and with decode alternately ready. The second run shows whether the queues stay in order and whether held beats stay stable. A sweep places a PC capture at each of 256 addresses, each with a different 8-bit displacement, under random backpressure and random data-side demand. This covers every displacement value and the turn-taking rule when the data side stays active. A stall program leaves the jump queue and then the condition queue empty for a long time, then checks that reads and beats stop and that they resume correctly once the entry arrives.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int unsigned IFU_W  = 16;
    localparam int unsigned OP_LSB = 12;

    localparam logic [3:0] OP_JUMP   = 4'h0;
    localparam logic [3:0] OP_BRANCH = 4'h1;
    localparam logic [3:0] OP_PCCAP  = 4'h7;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_ISSUE,
        ST_LATCH,
        ST_EXEC,
        ST_PCV
    } ifu_state_e;

    typedef struct packed {
        ifu_state_e       state;
        logic [IFU_W-1:0] pc;
        logic [IFU_W-1:0] ir;
        logic             ov;
        logic [IFU_W-1:0] od;
    } ifu_regs_t;

endpackage

// File: rtl/ifu_fifo.sv
module ifu_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_avail,
    output logic [WIDTH-1:0] out_data,
    input  logic             pop
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [WIDTH-1:0] slot_d [DEPTH];
    logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             push;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_ready  = (cnt_q != CNT_W'(DEPTH));
    assign out_avail = (cnt_q != '0);
    assign out_data  = slot_q[rd_q];
    assign push      = in_valid && in_ready;

    always_comb begin
        slot_d = slot_q;
        wr_d   = wr_q;
        rd_d   = rd_q;
        if (push) begin
            slot_d[wr_q] = in_data;
            wr_d         = step(wr_q);
        end
        if (pop) begin
            rd_d = step(rd_q);
        end
        cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
        slot_q <= slot_d;
    end

    // R10: an entry is only removed when one is held
    a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> out_avail);

    // R10: a full queue refuses new entries until one leaves
    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !pop) |=> !in_ready);

endmodule

// File: rtl/ifu_turn_arb.sv
module ifu_turn_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_issue,
    input  logic dside_req,
    output logic fetch_ok,
    output logic dside_gnt
);
    logic turn_q, turn_d;   // 0: fetch side's turn, 1: data side's turn

    assign fetch_ok  = !turn_q || !dside_req;
    assign dside_gnt = turn_q && dside_req;

    always_comb begin
        turn_d = turn_q;
        if (fetch_issue) begin
            turn_d = 1'b1;
        end else if (dside_gnt) begin
            turn_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) turn_q <= 1'b0;
        else        turn_q <= turn_d;
    end

    // R7: after a read, a waiting data side is served next
    a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_issue && dside_req) |=> (dside_req |-> dside_gnt));

    // R7: the port never serves both sides in one cycle
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_issue && dside_gnt));

endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
#(
    parameter int unsigned CC_DEPTH = 4,
    parameter int unsigned JT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [IFU_W-1:0]  mem_addr,
    input  logic [IFU_W-1:0]  mem_rdata,
    input  logic              dside_req,
    output logic              dside_gnt,
    input  logic              cc_valid,
    output logic              cc_ready,
    input  logic              cc_bit,
    input  logic              jt_valid,
    output logic              jt_ready,
    input  logic [IFU_W-1:0]  jt_addr,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [IFU_W-1:0]  dec_data
);
    localparam int unsigned BR_OFS_W = OP_LSB;
    localparam int unsigned PC_OFS_W = 8;

    ifu_regs_t        r_q, r_d;
    logic             fetch_ok;
    logic             cc_avail, cc_pop;
    logic [0:0]       cc_head;
    logic             jt_avail, jt_pop;
    logic [IFU_W-1:0] jt_head;
    logic [3:0]       op;
    logic             slot_free;
    logic [IFU_W-1:0] br_ofs, cap_ofs;

    ifu_fifo #(.WIDTH(1), .DEPTH(CC_DEPTH)) cc_q_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (cc_valid),
        .in_ready (cc_ready),
        .in_data  (cc_bit),
        .out_avail(cc_avail),
        .out_data (cc_head),
        .pop      (cc_pop)
    );

    ifu_fifo #(.WIDTH(IFU_W), .DEPTH(JT_DEPTH)) jt_q_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (jt_valid),
        .in_ready (jt_ready),
        .in_data  (jt_addr),
        .out_avail(jt_avail),
        .out_data (jt_head),
        .pop      (jt_pop)
    );

    ifu_turn_arb arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_issue(mem_rd),
        .dside_req  (dside_req),
        .fetch_ok   (fetch_ok),
        .dside_gnt  (dside_gnt)
    );

    assign op        = r_q.ir[IFU_W-1:OP_LSB];
    assign slot_free = !r_q.ov || dec_ready;
    assign br_ofs    = {{(IFU_W-BR_OFS_W){r_q.ir[BR_OFS_W-1]}}, r_q.ir[BR_OFS_W-1:0]};
    assign cap_ofs   = {{(IFU_W-PC_OFS_W){r_q.ir[PC_OFS_W-1]}}, r_q.ir[PC_OFS_W-1:0]};

    always_comb begin
        r_d    = r_q;
        mem_rd = 1'b0;
        cc_pop = 1'b0;
        jt_pop = 1'b0;
        if (r_q.ov && dec_ready) r_d.ov = 1'b0;
        unique case (r_q.state)
            ST_BOOT: r_d.state = ST_ISSUE;
            ST_ISSUE: begin
                if (fetch_ok) begin
                    mem_rd    = 1'b1;
                    r_d.state = ST_LATCH;
                end
            end
            ST_LATCH: begin
                r_d.ir    = mem_rdata;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                if (op == OP_JUMP) begin
                    if (jt_avail) begin
                        jt_pop    = 1'b1;
                        r_d.pc    = jt_head;
                        r_d.state = ST_ISSUE;
                    end
                end else if (op == OP_BRANCH) begin
                    if (cc_avail) begin
                        cc_pop    = 1'b1;
                        r_d.pc    = cc_head[0] ? r_q.pc + br_ofs : r_q.pc + 1'b1;
                        r_d.state = ST_ISSUE;
                    end
                end else if (slot_free) begin
                    r_d.ov = 1'b1;
                    r_d.od = r_q.ir;
                    if (op == OP_PCCAP) begin
                        r_d.state = ST_PCV;
                    end else begin
                        r_d.pc    = r_q.pc + 1'b1;
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            ST_PCV: begin
                if (slot_free) begin
                    r_d.ov    = 1'b1;
                    r_d.od    = r_q.pc + cap_ofs;
                    r_d.pc    = r_q.pc + 1'b1;
                    r_d.state = ST_ISSUE;
                end
            end
            default: r_d.state = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_BOOT;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.pc;
    assign dec_valid = r_q.ov;
    assign dec_data  = r_q.od;

    // R3: a served jump redirects the next read to the queued target
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_EXEC && op == OP_JUMP && jt_avail) |=> (mem_addr == $past(jt_head)));

    // R5: a control instruction facing an empty queue freezes the PC and reads nothing
    a_r5_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_EXEC &&
         ((op == OP_JUMP && !jt_avail) || (op == OP_BRANCH && !cc_avail)))
        |=> ($stable(mem_addr) && !mem_rd));

    // R8: a read strobe never lasts two cycles
    a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R9: a refused beat stays put
    a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_data)));

endmodule

// File: tb/ifu_top_tb_top.sv
`timescale 1ns/1ps
module ifu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        dside_req = 1'b0;
    logic        dside_gnt;
    logic        cc_valid = 1'b0, cc_ready, cc_bit = 1'b0;
    logic        jt_valid = 1'b0, jt_ready;
    logic [15:0] jt_addr = '0;
    logic        dec_valid, dec_ready = 1'b0;
    logic [15:0] dec_data;

    always #2.5 clk = ~clk;

    ifu_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dside_req(dside_req), .dside_gnt(dside_gnt),
        .cc_valid(cc_valid), .cc_ready(cc_ready), .cc_bit(cc_bit),
        .jt_valid(jt_valid), .jt_ready(jt_ready), .jt_addr(jt_addr),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_data(dec_data)
    );

    logic [15:0] mem [256];
    logic        cc_arr [8];
    logic [15:0] jt_arr [8];
    int          cc_n, jt_n, cc_i, jt_i, cc_dly, jt_dly;
    bit          cc_fire, jt_fire;
    int          n_chk = 0, n_bad = 0;
    int          cyc = 0;
    bit          running = 0, done = 0;
    int          rmode = 0, dmode = 0;
    bit          stall_chk = 0, full_chk = 0;
    bit          prev_rd = 0, prev_hold = 0;
    logic [15:0] hold_data = '0;
    logic [15:0] lfsr = 16'hACE1, dlfsr = 16'h1D2B;
    logic [15:0] act_w[$], act_a[$], exp_w[$], exp_a[$];

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // data-side demand changes shortly after the edge so it is settled at mid-cycle
    always @(posedge clk) begin
        #1;
        dlfsr = {dlfsr[14:0], dlfsr[15] ^ dlfsr[13] ^ dlfsr[12] ^ dlfsr[10]};
        if (!running)        dside_req = (dmode == 1);
        else if (dmode == 0) dside_req = 1'b0;
        else if (dmode == 1) dside_req = 1'b1;
        else                 dside_req = dlfsr[3];
    end

    always @(negedge clk) begin
        if (running) begin
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (prev_rd && dside_req)
                chk(dside_gnt, "R7 data side served after read", 32'(dside_gnt), 32'd1);
            if (!dside_req && dside_gnt)
                chk(1'b0, "R7 grant without request", 32'd1, 32'd0);
            if (mem_rd && dside_gnt)
                chk(1'b0, "R7 read during data grant", 32'd1, 32'd0);
            if (prev_rd && mem_rd)
                chk(1'b0, "R8 read strobe longer than one cycle", 32'd1, 32'd0);
            if (prev_hold)
                chk(dec_valid && dec_data == hold_data, "R9 held beat changed",
                    {15'd0, dec_valid, dec_data}, {16'd1, hold_data});
            if (mem_rd) act_a.push_back(mem_addr);
            prev_rd = mem_rd;
            if (cc_fire) cc_i++;
            cc_valid = (cyc >= cc_dly) && (cc_i < cc_n);
            cc_bit   = cc_arr[cc_i % 8];
            cc_fire  = cc_valid && cc_ready;
            if (jt_fire) jt_i++;
            jt_valid = (cyc >= jt_dly) && (jt_i < jt_n);
            jt_addr  = jt_arr[jt_i % 8];
            jt_fire  = jt_valid && jt_ready;
            dec_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : lfsr[0];
            if (dec_valid && dec_ready) act_w.push_back(dec_data);
            prev_hold = dec_valid && !dec_ready;
            hold_data = dec_data;
            if (full_chk && cyc == 10) begin
                chk(!cc_ready, "R10 condition queue full", 32'(cc_ready), 32'd0);
                chk(!jt_ready, "R10 jump queue full", 32'(jt_ready), 32'd0);
            end
            if (stall_chk && cyc == 55) begin
                chk(act_w.size() == 1, "R5 beats during jump stall", act_w.size(), 32'd1);
                chk(act_a.size() == 2, "R5 reads during jump stall", act_a.size(), 32'd2);
            end
            if (stall_chk && cyc == 110) begin
                chk(act_w.size() == 2, "R5 beats during branch stall", act_w.size(), 32'd2);
                chk(act_a.size() == 4, "R5 reads during branch stall", act_a.size(), 32'd4);
            end
        end
    end

    task automatic build_ref(input int n);
        logic [15:0] pc, ins;
        int ci, ji;
        pc = '0; ci = 0; ji = 0;
        exp_w.delete(); exp_a.delete();
        while (exp_w.size() < n && exp_a.size() < 4000) begin
            exp_a.push_back(pc);
            ins = mem[pc[7:0]];
            case (ins[15:12])
                4'h0: begin pc = jt_arr[ji % 8]; ji++; end
                4'h1: begin
                    pc = cc_arr[ci % 8] ? pc + {{4{ins[11]}}, ins[11:0]} : pc + 16'd1;
                    ci++;
                end
                4'h7: begin
                    exp_w.push_back(ins);
                    exp_w.push_back(pc + {{8{ins[7]}}, ins[7:0]});
                    pc = pc + 16'd1;
                end
                default: begin exp_w.push_back(ins); pc = pc + 16'd1; end
            endcase
        end
    endtask

    task automatic run_scn(input string name, input int n, input int rm, input int dm,
                           input int jd, input int cd, input int tmo, input bit stl, input bit ful);
        rst_n = 1'b0; running = 0;
        rmode = rm; dmode = dm; jt_dly = jd; cc_dly = cd;
        stall_chk = stl; full_chk = ful;
        cc_i = 0; jt_i = 0; cc_fire = 0; jt_fire = 0;
        cc_valid = 0; jt_valid = 0; dec_ready = 0;
        prev_rd = 0; prev_hold = 0;
        act_w.delete(); act_a.delete();
        repeat (3) @(negedge clk);
        chk(!dec_valid, "R1 no beat in reset", 32'(dec_valid), 32'd0);
        chk(!mem_rd, "R1 no read in reset", 32'(mem_rd), 32'd0);
        chk(mem_addr == 16'h0000, "R1 address in reset", 32'(mem_addr), 32'd0);
        rst_n = 1'b1; cyc = 0; running = 1;
        while (act_w.size() < n && cyc < tmo) @(negedge clk);
        running = 0;
        chk(act_w.size() >= n, {"R2 R6 stream complete ", name}, act_w.size(), n);
        build_ref(n);
        for (int i = 0; i < n && i < act_w.size(); i++)
            chk(act_w[i] == exp_w[i], $sformatf("R2 R6 R8 beat %0d %s", i, name), act_w[i], exp_w[i]);
        chk(act_a.size() >= exp_a.size(), {"R3 R4 read count ", name}, act_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < act_a.size(); i++)
            chk(act_a[i] == exp_a[i], $sformatf("R1 R3 R4 read address %0d %s", i, name), act_a[i], exp_a[i]);
    endtask

    task automatic load_mixed();
        for (int i = 0; i < 256; i++) mem[i] = 16'h8000;
        mem[8'h00] = 16'h8123; mem[8'h01] = 16'h7205; mem[8'h02] = 16'h72FE;
        mem[8'h03] = 16'h1005; mem[8'h04] = 16'h3BCD; mem[8'h05] = 16'h0000;
        mem[8'h06] = 16'h0000; mem[8'h08] = 16'h4321; mem[8'h09] = 16'h1003;
        mem[8'h0A] = 16'h2A55; mem[8'h0B] = 16'h1FFB; mem[8'h20] = 16'hF0F0;
        mem[8'h21] = 16'h0000; mem[8'h40] = 16'h6123; mem[8'h41] = 16'h5A12;
        mem[8'h42] = 16'h1002; mem[8'h43] = 16'h9999; mem[8'h44] = 16'h0000;
        for (int k = 0; k < 2; k++) begin
            cc_arr[4*k]   = 1'b1; cc_arr[4*k+1] = 1'b0;
            cc_arr[4*k+2] = 1'b1; cc_arr[4*k+3] = 1'b1;
            jt_arr[4*k]   = 16'h0020; jt_arr[4*k+1] = 16'h0004;
            jt_arr[4*k+2] = 16'h8040; jt_arr[4*k+3] = 16'h0000;
        end
        cc_n = 8; jt_n = 8;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // mixed program, decode always ready, queues fill up early (R2 R3 R4 R6 R10)
        load_mixed();
        run_scn("mixed-ready", 22, 0, 0, 0, 0, 3000, 0, 1);
        // same program, decode ready every other cycle, data side always asking (R7 R9)
        run_scn("mixed-backpressure", 22, 1, 1, 0, 0, 4000, 0, 0);
        // every 8-bit capture displacement under random backpressure and demand (R6 R7 R9)
        for (int k = 0; k < 256; k++) mem[k] = 16'h7000 | 16'(k);
        cc_n = 0; jt_n = 0;
        run_scn("capture-sweep", 512, 2, 2, 0, 0, 20000, 0, 0);
        // long empty queues: jump, then branch (R5)
        for (int i = 0; i < 256; i++) mem[i] = 16'h8000;
        mem[8'h00] = 16'h8001; mem[8'h01] = 16'h0000;
        mem[8'h10] = 16'hA001; mem[8'h11] = 16'h1003;
        mem[8'h14] = 16'hB002; mem[8'h15] = 16'h0000;
        jt_arr[0] = 16'h0010; jt_arr[1] = 16'h0000; jt_n = 2;
        cc_arr[0] = 1'b1; cc_n = 1;
        run_scn("empty-queue-stall", 3, 0, 0, 60, 120, 1000, 1, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule